// File: doc/BRIEF.md
# Floating-Point Status, Exception and Compare Unit

This block holds the floating-point status word of a processor and keeps it current as results arrive from the floating-point pipes. On each arithmetic result it takes five IEEE exception flags. It latches them as the current exceptions. It then checks them against the trap-enable mask held in the same word. If an enabled flag is set, it raises a trap request and records the IEEE trap type. If none is, it folds the flags into the sticky accrued field. On each compare result it writes a two-bit condition code into one of up to four condition fields. An unordered compare goes through the invalid-operation path.

Software can overwrite the whole word through a write port. That write wins over any datapath update in the same cycle. The two-bit rounding-mode field is exported so that the arithmetic units can use it. The block does no arithmetic or rounding of its own. Every update is registered. The trap pulse comes out in the same cycle as the status word that explains it.

Bit positions in the word (REG_W = 38):
- current exceptions: [4:0]
- accrued exceptions: [9:5]
- trap type: [16:14]
- trap enables: [27:23]
- rounding mode: [31:30]
- condition fields 0..3: at bits 10, 32, 34 and 36

Within each five-bit exception group the bit order is invalid [4], overflow [3], underflow [2], divide-by-zero [1], inexact [0].

Top module: `fpsr_unit`

## Requirements
- R1: On an arithmetic strobe (op_valid) without a software write, bits [4:0] of the register become op_flags exactly, in the order invalid [4], overflow [3], underflow [2], divide-by-zero [1], inexact [0].
- R2: If any bit of op_flags is set together with the matching trap-enable bit (register bit 23 + i for flag i), then in the following cycle trap_o is high for that one cycle and the trap-type field [16:14] holds 3'b001.
- R3: When an arithmetic strobe traps, the accrued field [9:5] keeps its value. When it does not trap, the accrued field becomes its old value ORed with op_flags, and the trap-type field is unchanged.
- R4: A compare strobe without an arithmetic strobe or software write writes cmp_rel into the selected condition field. The field sits at bits [11:10] for selector 0, [33:32] for 1, [35:34] for 2 and [37:36] for 3. The codes are 00 equal, 01 less, 10 greater, 11 unordered. All other condition fields are unchanged.
- R5: An unordered compare (cmp_rel = 11) traps when the invalid trap-enable bit 27 is set or cmp_signal is high. It then sets current bit 4, keeps the other current bits, sets the trap type to 3'b001, pulses trap_o and leaves the accrued field unchanged.
- R6: An unordered compare that does not trap sets accrued bit 9, leaves the current field and the trap type unchanged, and keeps trap_o low. An ordered compare changes only its condition field.
- R7: In a cycle with none of sw_we, op_valid or cmp_valid, the register holds its value and trap_o is low in the next cycle.
- R8: A software write loads sw_wdata into the whole register in the next cycle, overriding any arithmetic or compare strobe in the same cycle, and trap_o is low that cycle.
- R9: When op_valid and cmp_valid are both high without a software write, only the arithmetic update is applied and the compare is dropped.
- R10: round_o equals register bits [31:30], with 0 round to nearest, 1 toward zero, 2 toward plus infinity and 3 toward minus infinity.
- R11: While rst_n is low, the register is all zeros and trap_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we | input | 1 | Software write strobe for the whole register |
| sw_wdata | input | REG_W | Software write data |
| op_valid | input | 1 | Arithmetic result strobe |
| op_flags | input | 5 | IEEE flags of the result: invalid, overflow, underflow, divide-by-zero, inexact (bit 4 to bit 0) |
| cmp_valid | input | 1 | Compare result strobe |
| cmp_rel | input | 2 | Compare outcome: 00 equal, 01 less, 10 greater, 11 unordered |
| cmp_signal | input | 1 | Compare is the signalling variant, which traps on unordered |
| cmp_sel | input | SEL_W | Which condition field the compare writes |
| fsr_o | output | REG_W | Current status register value |
| trap_o | output | 1 | One-cycle trap request |
| round_o | output | 2 | Rounding-mode field |

## Verification
The hardest states to reach are the ones where the trap decision depends on enables that are themselves in the register. An unordered compare must trap through bit 27 alone, and a masked flag must accrue while an enabled flag on the very next result traps. The stimulus reaches these states by first loading chosen enable masks through the software port. It then issues flags and unordered compares both with and without the signalling bit. It also drives the collisions of software write with arithmetic strobe, and of arithmetic strobe with compare. A reference model in the bench, updated every cycle, follows a long random mix of all strobes.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
   localparam int FLAG_W   = 5;
   localparam int CEXC_LO  = 0;
   localparam int AEXC_LO  = CEXC_LO + FLAG_W;
   localparam int CC0_LO   = 10;
   localparam int FTT_LO   = 14;
   localparam int FTT_W    = 3;
   localparam int TEM_LO   = CEXC_LO + 23;
   localparam int RND_LO   = 30;
   localparam int NV_BIT   = 4;
   localparam logic [FTT_W-1:0] FTT_IEEE = 3'd1;

   typedef enum logic [1:0] {
      RND_NEAREST = 2'd0,
      RND_ZERO    = 2'd1,
      RND_UP      = 2'd2,
      RND_DOWN    = 2'd3
   } round_e;

   typedef enum logic [1:0] {
      REL_EQ = 2'd0,
      REL_LT = 2'd1,
      REL_GT = 2'd2,
      REL_UN = 2'd3
   } rel_e;

   // low bit of condition field k
   function automatic int cc_pos(input int k);
      return (k == 0) ? CC0_LO : CC0_LO + 20 + 2 * k;
   endfunction
endpackage

// File: rtl/fpsr_exc_path.sv
module fpsr_exc_path import fpsr_pkg::*; #(
   parameter int REG_W = 38
) (
   input  logic [REG_W-1:0]  cur,
   input  logic [FLAG_W-1:0] flags,
   output logic [REG_W-1:0]  nxt,
   output logic              trap
);
   logic [FLAG_W-1:0] armed;

   assign armed = flags & cur[TEM_LO +: FLAG_W];

   always_comb begin
      nxt = cur;
      nxt[CEXC_LO +: FLAG_W] = flags;
      trap = |armed;
      if (trap) begin
         nxt[FTT_LO +: FTT_W] = FTT_IEEE;
      end else begin
         nxt[AEXC_LO +: FLAG_W] = cur[AEXC_LO +: FLAG_W] | flags;
      end
   end
endmodule

// File: rtl/fpsr_cmp_path.sv
module fpsr_cmp_path import fpsr_pkg::*; #(
   parameter int REG_W     = 38,
   parameter int CC_FIELDS = 4,
   parameter int SEL_W     = 2
) (
   input  logic [REG_W-1:0] cur,
   input  logic [1:0]       rel,
   input  logic             signalling,
   input  logic [SEL_W-1:0] sel,
   output logic [REG_W-1:0] nxt,
   output logic             trap
);
   logic [CC_FIELDS-1:0] hit;
   logic                 unordered;

   for (genvar k = 0; k < CC_FIELDS; k++) begin : g_hit
      assign hit[k] = (sel == SEL_W'(k));
   end

   assign unordered = (rel_e'(rel) == REL_UN);

   always_comb begin
      nxt  = cur;
      trap = 1'b0;
      for (int k = 0; k < CC_FIELDS; k++) begin
         if (hit[k]) nxt[cc_pos(k) +: 2] = rel;
      end
      if (unordered) begin
         if (cur[TEM_LO + NV_BIT] || signalling) begin
            nxt[CEXC_LO + NV_BIT]    = 1'b1;
            nxt[FTT_LO +: FTT_W]     = FTT_IEEE;
            trap                     = 1'b1;
         end else begin
            nxt[AEXC_LO + NV_BIT]    = 1'b1;
         end
      end
   end
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit import fpsr_pkg::*; #(
   parameter int REG_W     = 38,
   parameter int CC_FIELDS = 4,
   parameter int SEL_W     = (CC_FIELDS > 1) ? $clog2(CC_FIELDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_we,
   input  logic [REG_W-1:0]  sw_wdata,
   input  logic              op_valid,
   input  logic [FLAG_W-1:0] op_flags,
   input  logic              cmp_valid,
   input  logic [1:0]        cmp_rel,
   input  logic              cmp_signal,
   input  logic [SEL_W-1:0]  cmp_sel,
   output logic [REG_W-1:0]  fsr_o,
   output logic              trap_o,
   output logic [1:0]        round_o
);
   localparam int TOP_USED = cc_pos(CC_FIELDS - 1) + 2;

   if (CC_FIELDS < 1 || CC_FIELDS > 4) begin : g_bad_fields
      $error("fpsr_unit: CC_FIELDS must be 1 to 4");
   end
   if (REG_W < TOP_USED || REG_W < RND_LO + 2) begin : g_bad_width
      $error("fpsr_unit: REG_W too small for the field layout");
   end

   logic [REG_W-1:0] fsr_q;
   logic             trap_q;
   logic [REG_W-1:0] exc_nxt, cmp_nxt;
   logic             exc_trap, cmp_trap;

   fpsr_exc_path #(.REG_W(REG_W)) u_exc (
      .cur   (fsr_q),
      .flags (op_flags),
      .nxt   (exc_nxt),
      .trap  (exc_trap)
   );

   fpsr_cmp_path #(.REG_W(REG_W), .CC_FIELDS(CC_FIELDS), .SEL_W(SEL_W)) u_cmp (
      .cur        (fsr_q),
      .rel        (cmp_rel),
      .signalling (cmp_signal),
      .sel        (cmp_sel),
      .nxt        (cmp_nxt),
      .trap       (cmp_trap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsr_q  <= '0;
         trap_q <= 1'b0;
      end else if (sw_we) begin
         fsr_q  <= sw_wdata;
         trap_q <= 1'b0;
      end else if (op_valid) begin
         fsr_q  <= exc_nxt;
         trap_q <= exc_trap;
      end else if (cmp_valid) begin
         fsr_q  <= cmp_nxt;
         trap_q <= cmp_trap;
      end else begin
         trap_q <= 1'b0;
      end
   end

   round_e rmode;
   assign rmode   = round_e'(fsr_q[RND_LO +: 2]);
   assign round_o = rmode;
   assign fsr_o   = fsr_q;
   assign trap_o  = trap_q;
endmodule

// File: rtl/fpsr_unit_chk.sv
module fpsr_unit_chk import fpsr_pkg::*; #(
   parameter int REG_W     = 38,
   parameter int CC_FIELDS = 4,
   parameter int SEL_W     = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sw_we,
   input logic [REG_W-1:0]  sw_wdata,
   input logic              op_valid,
   input logic [FLAG_W-1:0] op_flags,
   input logic              cmp_valid,
   input logic [1:0]        cmp_rel,
   input logic              cmp_signal,
   input logic [SEL_W-1:0]  cmp_sel,
   input logic [REG_W-1:0]  fsr_o,
   input logic              trap_o,
   input logic [1:0]        round_o
);
   function automatic logic [1:0] cc_at(input logic [REG_W-1:0] v, input logic [SEL_W-1:0] s);
      logic [1:0] r;
      r = 2'b00;
      for (int k = 0; k < CC_FIELDS; k++) begin
         if (s == SEL_W'(k)) r = v[cc_pos(k) +: 2];
      end
      return r;
   endfunction

   // R7
   a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_we && !op_valid && !cmp_valid) |=> ($stable(fsr_o) && !trap_o));

   // R8
   a_r8_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
      sw_we |=> (fsr_o == $past(sw_wdata) && !trap_o));

   // R1
   a_r1_cexc_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !sw_we) |=> (fsr_o[CEXC_LO +: FLAG_W] == $past(op_flags)));

   // R2
   a_r2_trap_type: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> (fsr_o[FTT_LO +: FTT_W] == FTT_IEEE));

   // R3
   a_r3_accrue: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !sw_we && ((op_flags & fsr_o[TEM_LO +: FLAG_W]) == '0)) |=>
      ((fsr_o[AEXC_LO +: FLAG_W] == ($past(fsr_o[AEXC_LO +: FLAG_W]) | $past(op_flags))) && !trap_o));

   // R4
   a_r4_cc_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && !op_valid && !sw_we) |=> (cc_at(fsr_o, $past(cmp_sel)) == $past(cmp_rel)));

   // R6
   a_r6_quiet_unordered: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && !op_valid && !sw_we && cmp_rel == 2'b11 && !cmp_signal && !fsr_o[TEM_LO + NV_BIT])
      |=> (fsr_o[AEXC_LO + NV_BIT] && !trap_o));

   // R10
   a_r10_round: assert property (@(posedge clk) disable iff (!rst_n)
      round_o == fsr_o[RND_LO +: 2]);
endmodule

bind fpsr_unit fpsr_unit_chk #(.REG_W(REG_W), .CC_FIELDS(CC_FIELDS), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/fpsr_unit_test.sv
module fpsr_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int W = 38;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sw_we = 1'b0;
   logic [W-1:0]  sw_wdata = '0;
   logic          op_valid = 1'b0;
   logic [4:0]    op_flags = '0;
   logic          cmp_valid = 1'b0;
   logic [1:0]    cmp_rel = '0;
   logic          cmp_signal = 1'b0;
   logic [1:0]    cmp_sel = '0;
   logic [W-1:0]  fsr_o;
   logic          trap_o;
   logic [1:0]    round_o;

   int n_checks = 0;
   int n_fail = 0;
   logic [W-1:0] m_reg = '0;
   logic         m_trap = 1'b0;
   string        cur_req = "R11";

   always #(CLK_PERIOD/2) clk = ~clk;

   fpsr_unit uut (
      .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata),
      .op_valid(op_valid), .op_flags(op_flags), .cmp_valid(cmp_valid),
      .cmp_rel(cmp_rel), .cmp_signal(cmp_signal), .cmp_sel(cmp_sel),
      .fsr_o(fsr_o), .trap_o(trap_o), .round_o(round_o)
   );

   task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic int cc_bit(input logic [1:0] s);
      case (s)
         2'd0: return 10;
         2'd1: return 32;
         2'd2: return 34;
         default: return 36;
      endcase
   endfunction

   // behavioural model of one clock edge
   task automatic model_step();
      m_trap = 1'b0;
      if (sw_we) begin
         m_reg = sw_wdata;
      end else if (op_valid) begin
         m_reg[4:0] = op_flags;
         if ((op_flags & m_reg[27:23]) != 0) begin
            m_reg[16:14] = 3'b001;
            m_trap = 1'b1;
         end else begin
            m_reg[9:5] = m_reg[9:5] | op_flags;
         end
      end else if (cmp_valid) begin
         m_reg[cc_bit(cmp_sel) +: 2] = cmp_rel;
         if (cmp_rel == 2'b11) begin
            if (m_reg[27] || cmp_signal) begin
               m_reg[4] = 1'b1;
               m_reg[16:14] = 3'b001;
               m_trap = 1'b1;
            end else begin
               m_reg[9] = 1'b1;
            end
         end
      end
   endtask

   task automatic compare_all();
      check(cur_req, "register", 64'(fsr_o), 64'(m_reg));
      check(cur_req, "trap", 64'(trap_o), 64'(m_trap));
      check("R10", "round", 64'(round_o), 64'(m_reg[31:30]));
   endtask

   task automatic cyc(input string req, input logic swe, input logic [W-1:0] wd,
                      input logic opv, input logic [4:0] fl,
                      input logic cv, input logic [1:0] rel, input logic sig, input logic [1:0] sel);
      cur_req    = req;
      sw_we      = swe;
      sw_wdata   = wd;
      op_valid   = opv;
      op_flags   = fl;
      cmp_valid  = cv;
      cmp_rel    = rel;
      cmp_signal = sig;
      cmp_sel    = sel;
      @(posedge clk);
      #1;
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle(input string req);
      cyc(req, 1'b0, '0, 1'b0, 5'd0, 1'b0, 2'd0, 1'b0, 2'd0);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11", "reset register", 64'(fsr_o), 64'd0);
      check("R11", "reset trap", 64'(trap_o), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      idle("R7");
      // R1 / R3: masked flags accrue
      cyc("R1", 1'b0, '0, 1'b1, 5'b10101, 1'b0, 2'd0, 1'b0, 2'd0);
      check("R3", "accrued", 64'(fsr_o[9:5]), 64'h15);
      cyc("R3", 1'b0, '0, 1'b1, 5'b00010, 1'b0, 2'd0, 1'b0, 2'd0);
      check("R3", "accrued or", 64'(fsr_o[9:5]), 64'h17);
      check("R1", "current copy", 64'(fsr_o[4:0]), 64'h02);
      // R8 load overflow enable and round-up mode
      cyc("R8", 1'b1, (W'(1) << 26) | (W'(2) << 30), 1'b0, 5'd0, 1'b0, 2'd0, 1'b0, 2'd0);
      check("R10", "round up", 64'(round_o), 64'd2);
      cyc("R3", 1'b0, '0, 1'b1, 5'b00001, 1'b0, 2'd0, 1'b0, 2'd0);
      check("R3", "no trap on masked", 64'(trap_o), 64'd0);
      // R2 enabled overflow traps, accrued unchanged
      cyc("R2", 1'b0, '0, 1'b1, 5'b01001, 1'b0, 2'd0, 1'b0, 2'd0);
      check("R2", "trap pulse", 64'(trap_o), 64'd1);
      check("R2", "trap type", 64'(fsr_o[16:14]), 64'd1);
      check("R3", "accrued held on trap", 64'(fsr_o[9:5]), 64'h01);
      idle("R7");
      check("R2", "pulse one cycle", 64'(trap_o), 64'd0);
      // R4 every field, ordered codes
      for (int s = 0; s < 4; s++) begin
         for (int r = 0; r < 3; r++) begin
            cyc("R4", 1'b0, '0, 1'b0, 5'd0, 1'b1, 2'(r), 1'b0, 2'(s));
            check("R4", "cc field", 64'(fsr_o[cc_bit(2'(s)) +: 2]), 64'(r));
         end
      end
      // R6 quiet unordered, enable off
      cyc("R6", 1'b0, '0, 1'b0, 5'd0, 1'b1, 2'd3, 1'b0, 2'd2);
      check("R6", "accrued nv", 64'(fsr_o[9]), 64'd1);
      check("R6", "no trap", 64'(trap_o), 64'd0);
      // R5 signalling unordered
      cyc("R5", 1'b0, '0, 1'b0, 5'd0, 1'b1, 2'd3, 1'b1, 2'd1);
      check("R5", "trap", 64'(trap_o), 64'd1);
      check("R5", "current nv", 64'(fsr_o[4]), 64'd1);
      // R5 quiet unordered with enable bit 27
      cyc("R8", 1'b1, W'(1) << 27, 1'b0, 5'd0, 1'b0, 2'd0, 1'b0, 2'd0);
      cyc("R5", 1'b0, '0, 1'b0, 5'd0, 1'b1, 2'd3, 1'b0, 2'd3);
      check("R5", "trap via enable", 64'(trap_o), 64'd1);
      check("R5", "accrued untouched", 64'(fsr_o[9:5]), 64'd0);
      // R8 software write beats arithmetic strobe
      cyc("R8", 1'b1, W'(38'h0012345678), 1'b1, 5'b10000, 1'b1, 2'd3, 1'b1, 2'd0);
      check("R8", "sw wins", 64'(fsr_o), 64'h0012345678);
      // R9 arithmetic beats compare
      cyc("R9", 1'b0, '0, 1'b1, 5'b00100, 1'b1, 2'd2, 1'b0, 2'd0);
      check("R9", "compare dropped", 64'(fsr_o[11:10]), 64'(m_reg[11:10]));
      // R10 each rounding mode
      for (int k = 0; k < 4; k++) begin
         cyc("R10", 1'b1, W'(k) << 30, 1'b0, 5'd0, 1'b0, 2'd0, 1'b0, 2'd0);
         check("R10", "mode", 64'(round_o), 64'(k));
      end
      // mixed random traffic, R7 and all strobes
      for (int i = 0; i < 400; i++) begin
         logic [3:0] pick;
         pick = 4'($urandom);
         cyc((pick == 0) ? "R8" : (pick < 6) ? "R1" : (pick < 11) ? "R4" : "R7",
             pick == 0, W'({$urandom, $urandom}) & ~(W'(1) << 27),
             pick inside {[1:5], 15}, 5'($urandom),
             pick inside {[6:10], 15}, 2'($urandom), 1'($urandom), 2'($urandom));
      end
      summary();
      $finish;
   end
endmodule